// File: doc/BRIEF.md
# Telecommand Interrupt Pending Register Set

This block sits between the event strobes of a telecommand receiver and the processor's interrupt line. Six one-cycle event inputs each set a sticky pending bit. Software sees those bits through six word registers on a simple read/write port. Two registers show the raw pending bits and two show the pending bits after masking. In each pair, one view clears the bits it returns when read and the other does not. A mask register selects which sources may raise the interrupt. A write-one-to-clear register discards pending bits directly.

The single interrupt output is a registered level. It is high one cycle after any pending bit meets a set mask bit, and it stays high until those bits are cleared or masked. A masked source keeps its pending bit, so a later poll still finds the event. Reset leaves the mask at zero, so a stopped receiver signals nothing until software arms it again.

Top module: `tc_irq_regs`

## Requirements
- R1: After reset every pending bit and every mask bit is 0, `irq` is 0 and `rdata` is 0.
- R2: An event pulse in a cycle sets its pending bit at that clock edge. The bit map is: bit 0 overrun, bit 1 unit stored, bit 2 carrier change, bit 3 acceptance report, bit 4 bit lock change, bit 5 report ready. A pending bit never becomes set without its event.
- R3: A read of address 0x6C returns the pending bits in bits 5..0, with 0 above them, and changes no pending bit.
- R4: A read of address 0x68 returns the pending bits and clears exactly the bits it returned.
- R5: A read of address 0x64 returns pending AND mask and changes no pending bit.
- R6: A read of address 0x60 returns pending AND mask and clears only those returned bits. Pending bits that are masked off stay set.
- R7: Address 0x70 is the mask. A write stores wdata bits 5..0, and a read returns them with 0 above.
- R8: A write to address 0x74 clears each pending bit whose wdata bit is 1. Writing 0x3F clears all of them. A read of 0x74 returns 0.
- R9: An event in the same cycle as a clear of that bit, by read or by write, leaves the bit set.
- R10: `irq` is 1 in the cycle after pending AND mask is nonzero, and 0 in the cycle after it is zero.
- R11: A source whose mask bit is 0 stays pending but does not drive `irq`.
- R12: `rdata` is registered. It holds the value selected by a read in the cycle after `rd_en`. It is 0 after a cycle with no read or with an unmapped address. Writes to the read-only addresses 0x60, 0x64, 0x68 and 0x6C change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| evt | input | 6 | One-cycle event strobes, bit map as in R2 |
| rd_en | input | 1 | Read strobe |
| wr_en | input | 1 | Write strobe |
| addr | input | 8 | Byte address of the register |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Registered read data |
| irq | output | 1 | Level interrupt request |

## Verification
A wrong pending bit shows at the ports in two ways. It appears on `rdata` in the cycle after the next read of any pending view. If its mask bit is set, it also appears on `irq` one cycle after the fault. Because the bench reads these views under random traffic, a bit cleared in error is caught within a few cycles. The same holds for a bit that survives a clear, and for a clear that beats a simultaneous event. A mask fault shows on the next mask read, and on `irq` as soon as any source is pending.

// File: rtl/tc_irq_regs.sv
module tc_irq_regs #(
  parameter int NSRC = 6,
  parameter int AW   = 8,
  parameter int DW   = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] evt,
  input  logic            rd_en,
  input  logic            wr_en,
  input  logic [AW-1:0]   addr,
  input  logic [DW-1:0]   wdata,
  output logic [DW-1:0]   rdata,
  output logic            irq
);
  localparam logic [AW-1:0] A_MSTAT = AW'('h60);
  localparam logic [AW-1:0] A_MPEND = AW'('h64);
  localparam logic [AW-1:0] A_STAT  = AW'('h68);
  localparam logic [AW-1:0] A_RAW   = AW'('h6C);
  localparam logic [AW-1:0] A_MASK  = AW'('h70);
  localparam logic [AW-1:0] A_CLR   = AW'('h74);

  logic [NSRC-1:0] pend, mask, clr, sel;
  logic [DW-1:0]   rd_mux;

  wire [NSRC-1:0] live = pend & mask;

  always_comb begin
    sel = '0;
    unique case (addr)
      A_MSTAT, A_MPEND: sel = live;
      A_STAT,  A_RAW:   sel = pend;
      A_MASK:           sel = mask;
      default:          sel = '0;
    endcase
    rd_mux = DW'(sel);
  end

  always_comb begin
    clr = '0;
    if (rd_en && (addr == A_STAT))  clr = clr | pend;
    if (rd_en && (addr == A_MSTAT)) clr = clr | live;
    if (wr_en && (addr == A_CLR))   clr = clr | wdata[NSRC-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend  <= '0;
      mask  <= '0;
      irq   <= 1'b0;
      rdata <= '0;
    end else begin
      pend  <= (pend & ~clr) | evt;
      if (wr_en && (addr == A_MASK)) mask <= wdata[NSRC-1:0];
      irq   <= |live;
      rdata <= rd_en ? rd_mux : '0;
    end
  end

  assert_pend_source_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> ((pend & ~$past(pend) & ~$past(evt)) == '0));

  assert_evt_beats_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> ((pend & $past(evt)) == $past(evt)));

  assert_raw_read_keeps_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && addr == A_RAW && !wr_en) |=> ((pend & $past(pend)) == $past(pend)));

  assert_mask_write_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == A_MASK) |=> (mask == $past(wdata[NSRC-1:0])));

  assert_irq_on_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (|(pend & mask)) |=> irq);

  assert_irq_off_R11: assert property (@(posedge clk) disable iff (!rst_n)
    ((pend & mask) == '0) |=> !irq);

  assert_clr_reads_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && addr == A_CLR) |=> (rdata == '0));
endmodule

// File: tb/tb_tc_irq_regs.sv
module tb_tc_irq_regs;
  localparam int CLK_PERIOD = 10;
  localparam int NS = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [NS-1:0] evt = '0;
  logic rd_en = 1'b0, wr_en = 1'b0;
  logic [7:0] addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic irq;

  int checks = 0, errors = 0;
  logic [NS-1:0] m_pend = '0, m_mask = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  tc_irq_regs dut (.clk(clk), .rst_n(rst_n), .evt(evt), .rd_en(rd_en), .wr_en(wr_en),
                   .addr(addr), .wdata(wdata), .rdata(rdata), .irq(irq));

  function automatic logic [31:0] model_read(input logic [7:0] a);
    case (a)
      8'h60, 8'h64: return 32'(m_pend & m_mask);
      8'h68, 8'h6C: return 32'(m_pend);
      8'h70:        return 32'(m_mask);
      default:      return 32'h0;
    endcase
  endfunction

  task automatic check(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic step(input logic [NS-1:0] ev, input logic rd, input logic wr,
                      input logic [7:0] a, input logic [31:0] wd, input string tag);
    logic [31:0] exp_rd;
    logic exp_irq;
    logic [NS-1:0] clr;
    evt = ev; rd_en = rd; wr_en = wr; addr = a; wdata = wd;
    @(posedge clk);
    exp_rd  = rd ? model_read(a) : 32'h0;
    exp_irq = |(m_pend & m_mask);
    clr = '0;
    if (rd && a == 8'h68) clr = clr | m_pend;
    if (rd && a == 8'h60) clr = clr | (m_pend & m_mask);
    if (wr && a == 8'h74) clr = clr | wd[NS-1:0];
    m_pend = (m_pend & ~clr) | ev;
    if (wr && a == 8'h70) m_mask = wd[NS-1:0];
    @(negedge clk);
    evt = '0; rd_en = 1'b0; wr_en = 1'b0;
    check(tag, "rdata", rdata, exp_rd);
    check(tag, "irq", 32'(irq), 32'(exp_irq));
  endtask

  initial begin
    #(CLK_PERIOD*100000);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    check("R1", "rdata after reset", rdata, 32'h0);
    check("R1", "irq after reset", 32'(irq), 32'h0);
    rst_n = 1'b1;
    @(negedge clk);
    step('0, 1, 0, 8'h6C, 0, "R1");
    step('0, 1, 0, 8'h70, 0, "R1");

    step(6'b000001, 0, 0, 8'h00, 0, "R2");
    step(6'b100010, 0, 0, 8'h00, 0, "R2");
    step('0, 1, 0, 8'h6C, 0, "R3");
    step('0, 1, 0, 8'h6C, 0, "R3");
    step('0, 0, 1, 8'h6C, 32'h3F, "R12");
    step('0, 0, 1, 8'h60, 32'h3F, "R12");
    step('0, 1, 0, 8'h6C, 0, "R12");
    step('0, 1, 0, 8'h90, 0, "R12");
    step('0, 1, 0, 8'h74, 0, "R8");

    step('0, 0, 1, 8'h70, 32'hFFFF_FF02, "R7");
    step('0, 1, 0, 8'h70, 0, "R7");
    step('0, 1, 0, 8'h64, 0, "R5");
    step('0, 1, 0, 8'h64, 0, "R10");
    step('0, 1, 0, 8'h60, 0, "R6");
    step('0, 1, 0, 8'h6C, 0, "R11");
    step('0, 0, 0, 8'h00, 0, "R11");
    step('0, 1, 0, 8'h68, 0, "R4");
    step('0, 1, 0, 8'h68, 0, "R4");

    step(6'b111111, 0, 0, 8'h00, 0, "R2");
    step(6'b000100, 1, 0, 8'h68, 0, "R9");
    step('0, 1, 0, 8'h6C, 0, "R9");
    step(6'b001000, 0, 1, 8'h74, 32'h3F, "R9");
    step('0, 1, 0, 8'h6C, 0, "R9");
    step(6'b011011, 0, 0, 8'h00, 0, "R8");
    step('0, 0, 1, 8'h74, 32'h3F, "R8");
    step('0, 1, 0, 8'h6C, 0, "R8");

    for (int i = 0; i < 2000; i++) begin
      logic [2:0] pick;
      logic [7:0] a;
      pick = 3'($urandom_range(0, 6));
      a = (pick == 3'd6) ? 8'h78 : 8'h60 + {3'b0, pick, 2'b00};
      step(NS'($urandom & $urandom), ($urandom % 3) == 0, ($urandom % 4) == 0, a,
           $urandom, "R10 random");
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule